// File: doc/BRIEF.md
# Five-Port Mesh Packet Router

This block is the switching element placed at every node of a two-dimensional on-chip mesh. It has five ports: one toward the local resource and one toward each of the four neighbouring routers. Each port has a separate incoming link and a separate outgoing link, and both use a valid/ready handshake. Every packet is a single flit. The flit carries a destination column and row in its upper bits and a payload in its lower bits.

Every incoming link writes into a small FIFO queue of its own. Routing is fixed and always minimal, and it looks only at the flit at the head of each queue. The router compares the destination column with the node's own column and moves the packet horizontally until the two match. It then compares rows and moves the packet vertically. When both coordinates match, the packet goes to the local port. Each output has its own round-robin arbiter that chooses among the queue heads that want that output. A head flit leaves its queue only in a cycle where the chosen output's receiver is ready.

The node coordinates, the coordinate widths, the payload width and the queue depth are all parameters.

Top module: `meshRouter`

## Requirements
- R1: While reset is active and in the first cycle after it, every output valid is low and every input ready is high.
- R2: Flit layout: bits [FLIT_W-1 -: X_W] hold the destination column and the next Y_W bits hold the destination row. Port indices are local=0, north=1, east=2, south=3, west=4.
- R3: Routing goes column first. A destination column greater than MY_X goes to east, and a smaller one goes to west. When the columns are equal, a destination row greater than MY_Y goes to north and a smaller one goes to south. When both coordinates are equal, the flit goes to local.
- R4: A flit accepted at a clock edge, on any input, appears on its output immediately after that edge if the output is free, with its content unchanged. It is presented for exactly one transfer.
- R5: Each input queue holds DEPTH flits. While its queue is full, that input's ready is low. Flits from one input leave in the order they arrived.
- R6: While an output is valid and its ready is low, the output stays valid and its data does not change in the next cycle.
- R7: Inputs competing for one output are served round-robin. The search starts at the input after the last one that completed a transfer on that output, and stalled cycles do not move the starting point.
- R8: Flits headed for different outputs leave in the same cycle, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 5 | Flit present on each incoming link |
| inData | input | 5 x FLIT_W | Flit on each incoming link |
| inReady | output | 5 | Input queue can accept a flit |
| outValid | output | 5 | Flit offered on each outgoing link |
| outData | output | 5 x FLIT_W | Flit on each outgoing link |
| outReady | input | 5 | Downstream router or resource accepts the flit |

## Verification
A flit that is accepted at a rising edge appears on its output right after that same edge, because the queue head is read through combinational logic. The bench therefore drives the flit at a falling edge and checks the outputs at the next falling edge. One more falling edge later, the bench confirms that the flit was sent only once. For the queue-full, stall and rotation cases, every check falls half a cycle after the edge that caused the change. Each release sequence is read back one falling edge per flit, so each check sees exactly one transfer.

// File: rtl/meshRouterPkg.sv
package meshRouterPkg;
  localparam int NPORTS = 5;
  localparam int PTR_W  = 3;

  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_SOUTH = 3;
  localparam int P_WEST  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NPORTS-1:0]             pop;   // dequeue head of input i
    logic [NPORTS-1:0][NPORTS-1:0] sel;   // sel[o][i]: output o carries input i
    logic [NPORTS-1:0]             fire;  // output o valid
  } xbarCtl_t;
endpackage

// File: rtl/meshRouterFifo.sv
module meshRouterFifo #(
  parameter int W     = 38,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign dout  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (push && !full)
        wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop && !empty)
        rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/meshRouterDp.sv
module meshRouterDp
  import meshRouterPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int DEPTH  = 4,
  localparam int FLIT_W = DATA_W + X_W + Y_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NPORTS-1:0]              inValid,
  input  logic [NPORTS-1:0][FLIT_W-1:0]  inData,
  output logic [NPORTS-1:0]              inReady,
  output logic [NPORTS-1:0]              outValid,
  output logic [NPORTS-1:0][FLIT_W-1:0]  outData,
  input  xbarCtl_t                       ctl,
  output logic [NPORTS-1:0]              headValid,
  output logic [NPORTS-1:0][X_W-1:0]     headX,
  output logic [NPORTS-1:0][Y_W-1:0]     headY
);
  logic [NPORTS-1:0][FLIT_W-1:0] head;

  for (genvar i = 0; i < NPORTS; i++) begin : g_in
    logic qEmpty, qFull;
    meshRouterFifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rstN  (rstN),
      .push  (inValid[i]),
      .din   (inData[i]),
      .pop   (ctl.pop[i]),
      .dout  (head[i]),
      .empty (qEmpty),
      .full  (qFull)
    );
    assign inReady[i]   = ~qFull;
    assign headValid[i] = ~qEmpty;
    assign headX[i]     = head[i][FLIT_W-1 -: X_W];
    assign headY[i]     = head[i][FLIT_W-1-X_W -: Y_W];
  end

  // AND-OR crossbar driven by one-hot selects
  always_comb begin
    for (int o = 0; o < NPORTS; o++) begin
      outData[o] = '0;
      for (int i = 0; i < NPORTS; i++)
        outData[o] = outData[o] | ({FLIT_W{ctl.sel[o][i]}} & head[i]);
    end
  end

  assign outValid = ctl.fire;
endmodule

// File: rtl/meshRouterCtrl.sv
module meshRouterCtrl
  import meshRouterPkg::*;
#(
  parameter int X_W  = 3,
  parameter int Y_W  = 3,
  parameter int MY_X = 2,
  parameter int MY_Y = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NPORTS-1:0]          headValid,
  input  logic [NPORTS-1:0][X_W-1:0] headX,
  input  logic [NPORTS-1:0][Y_W-1:0] headY,
  input  logic [NPORTS-1:0]          outReady,
  output xbarCtl_t                   ctl
);
  logic [NPORTS-1:0][NPORTS-1:0] routeOh;   // routeOh[i][o]
  logic [NPORTS-1:0][NPORTS-1:0] selArr;    // selArr[o][i]
  logic [NPORTS-1:0]             fireVec;

  // Column-first minimal routing of each queue head
  for (genvar i = 0; i < NPORTS; i++) begin : g_route
    always_comb begin
      routeOh[i] = '0;
      if (headX[i] > X_W'(MY_X))      routeOh[i][P_EAST]  = 1'b1;
      else if (headX[i] < X_W'(MY_X)) routeOh[i][P_WEST]  = 1'b1;
      else if (headY[i] > Y_W'(MY_Y)) routeOh[i][P_NORTH] = 1'b1;
      else if (headY[i] < Y_W'(MY_Y)) routeOh[i][P_SOUTH] = 1'b1;
      else                            routeOh[i][P_LOCAL] = 1'b1;
    end
  end

  // Round-robin arbiter with grant lock while stalled
  for (genvar o = 0; o < NPORTS; o++) begin : g_arb
    logic [NPORTS-1:0] req;
    logic [PTR_W-1:0]  ptr, lockIdx, rrIdx, grantIdx;
    logic              lockOn, anyReq;

    always_comb begin
      for (int i = 0; i < NPORTS; i++) req[i] = headValid[i] & routeOh[i][o];
    end

    always_comb begin
      int idx;
      anyReq = 1'b0;
      rrIdx  = '0;
      for (int k = 0; k < NPORTS; k++) begin
        idx = int'(ptr) + k;
        if (idx >= NPORTS) idx = idx - NPORTS;
        if (!anyReq && req[idx]) begin
          anyReq = 1'b1;
          rrIdx  = PTR_W'(idx);
        end
      end
    end

    assign grantIdx   = lockOn ? lockIdx : rrIdx;
    assign fireVec[o] = lockOn | anyReq;

    always_comb begin
      selArr[o] = '0;
      if (fireVec[o]) selArr[o][grantIdx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptr     <= '0;
        lockOn  <= 1'b0;
        lockIdx <= '0;
      end else if (fireVec[o]) begin
        if (outReady[o]) begin
          ptr    <= (grantIdx == PTR_W'(NPORTS-1)) ? '0 : grantIdx + 1'b1;
          lockOn <= 1'b0;
        end else begin
          lockOn  <= 1'b1;
          lockIdx <= grantIdx;
        end
      end
    end
  end

  // An input pops when the output that selected it completes a transfer
  always_comb begin
    ctl.pop = '0;
    for (int o = 0; o < NPORTS; o++)
      for (int i = 0; i < NPORTS; i++)
        if (selArr[o][i] && outReady[o]) ctl.pop[i] = 1'b1;
  end

  assign ctl.sel  = selArr;
  assign ctl.fire = fireVec;
endmodule

// File: rtl/meshRouter.sv
module meshRouter
  import meshRouterPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int DEPTH  = 4,
  parameter int MY_X   = 2,
  parameter int MY_Y   = 2,
  localparam int FLIT_W = DATA_W + X_W + Y_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NPORTS-1:0]             inValid,
  input  logic [NPORTS-1:0][FLIT_W-1:0] inData,
  output logic [NPORTS-1:0]             inReady,
  output logic [NPORTS-1:0]             outValid,
  output logic [NPORTS-1:0][FLIT_W-1:0] outData,
  input  logic [NPORTS-1:0]             outReady
);
  xbarCtl_t                   ctl;
  logic [NPORTS-1:0]          headValid;
  logic [NPORTS-1:0][X_W-1:0] headX;
  logic [NPORTS-1:0][Y_W-1:0] headY;

  meshRouterDp #(.DATA_W(DATA_W), .X_W(X_W), .Y_W(Y_W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inData    (inData),
    .inReady   (inReady),
    .outValid  (outValid),
    .outData   (outData),
    .ctl       (ctl),
    .headValid (headValid),
    .headX     (headX),
    .headY     (headY)
  );

  meshRouterCtrl #(.X_W(X_W), .Y_W(Y_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .headValid (headValid),
    .headX     (headX),
    .headY     (headY),
    .outReady  (outReady),
    .ctl       (ctl)
  );
endmodule

// File: rtl/meshRouterChk.sv
module meshRouterChk
  import meshRouterPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int DEPTH  = 4,
  parameter int MY_X   = 2,
  parameter int MY_Y   = 2,
  localparam int FLIT_W = DATA_W + X_W + Y_W
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NPORTS-1:0]             inValid,
  input logic [NPORTS-1:0]             inReady,
  input logic [NPORTS-1:0]             outValid,
  input logic [NPORTS-1:0][FLIT_W-1:0] outData,
  input logic [NPORTS-1:0]             outReady
);
  logic [NPORTS-1:0][X_W-1:0] dX;
  logic [NPORTS-1:0][Y_W-1:0] dY;
  logic [7:0] inFlight;

  for (genvar p = 0; p < NPORTS; p++) begin : g_f
    assign dX[p] = outData[p][FLIT_W-1 -: X_W];
    assign dY[p] = outData[p][FLIT_W-1-X_W -: Y_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + 8'($countones(inValid & inReady))
                              - 8'($countones(outValid & outReady));
  end

  // R1
  idle_in_reset_chk: assert property (@(posedge clk) !rstN |-> (outValid == '0 && inReady == '1));

  // R5
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(inFlight) <= NPORTS*DEPTH);

  // R3
  east_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[P_EAST] |-> dX[P_EAST] > X_W'(MY_X));
  // R3
  west_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[P_WEST] |-> dX[P_WEST] < X_W'(MY_X));
  // R3
  north_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[P_NORTH] |-> (dX[P_NORTH] == X_W'(MY_X) && dY[P_NORTH] > Y_W'(MY_Y)));
  // R3
  south_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[P_SOUTH] |-> (dX[P_SOUTH] == X_W'(MY_X) && dY[P_SOUTH] < Y_W'(MY_Y)));
  // R3
  local_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid[P_LOCAL] |-> (dX[P_LOCAL] == X_W'(MY_X) && dY[P_LOCAL] == Y_W'(MY_Y)));

  for (genvar p = 0; p < NPORTS; p++) begin : g_hold
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[p] && !outReady[p]) |=> (outValid[p] && $stable(outData[p])));
  end
endmodule

bind meshRouter meshRouterChk #(
  .DATA_W(DATA_W), .X_W(X_W), .Y_W(Y_W), .DEPTH(DEPTH), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outData  (outData),
  .outReady (outReady)
);

// File: tb/meshRouter_bench.sv
module meshRouter_bench;
  localparam int NP     = 5;
  localparam int DATA_W = 32;
  localparam int X_W    = 3;
  localparam int Y_W    = 3;
  localparam int DEPTH  = 4;
  localparam int FLIT_W = DATA_W + X_W + Y_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]             inValid = '0;
  logic [NP-1:0][FLIT_W-1:0] inData  = '0;
  logic [NP-1:0]             inReady;
  logic [NP-1:0]             outValid;
  logic [NP-1:0][FLIT_W-1:0] outData;
  logic [NP-1:0]             outReady = '1;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  meshRouter u_meshRouter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  // {input port, dst x, dst y, payload, expected output port}; node at (2,2)
  localparam int VEC [9][5] = '{
    '{4, 5, 2, 'h11, 2},
    '{2, 0, 2, 'h22, 4},
    '{0, 2, 6, 'h33, 1},
    '{1, 2, 1, 'h44, 3},
    '{3, 2, 2, 'h55, 0},
    '{0, 7, 0, 'h66, 2},
    '{2, 1, 7, 'h77, 4},
    '{4, 2, 3, 'h88, 1},
    '{1, 2, 2, 'h99, 0}
  };

  function automatic logic [FLIT_W-1:0] mk(int x, int y, int pl);
    return {X_W'(x), Y_W'(y), DATA_W'(pl)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    check(outValid == '0 && inReady == '1, "R1", {outValid, inReady}, {5'd0, 5'h1f});
    rstN = 1'b1;
    @(negedge clk);
    // R1 after release
    check(outValid == '0 && inReady == '1, "R1", {outValid, inReady}, {5'd0, 5'h1f});

    // Table walk: R2/R3 routing and R4 one-cycle delivery
    for (int v = 0; v < 9; v++) begin
      inData[VEC[v][0]]  = mk(VEC[v][1], VEC[v][2], VEC[v][3]);
      inValid[VEC[v][0]] = 1'b1;
      @(negedge clk);
      inValid = '0;
      check(outValid == NP'(1 << VEC[v][4]), "R3", 64'(outValid), 64'(1 << VEC[v][4]));
      check(outData[VEC[v][4]] == mk(VEC[v][1], VEC[v][2], VEC[v][3]), "R4",
            64'(outData[VEC[v][4]]), 64'(mk(VEC[v][1], VEC[v][2], VEC[v][3])));
      @(negedge clk);
      check(outValid == '0, "R4", 64'(outValid), 64'd0);
    end

    // R5: fill local queue toward a stalled east output
    outReady[2] = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      inData[0]  = mk(5, 2, 'h100 + k);
      inValid[0] = 1'b1;
      @(negedge clk);
    end
    inValid = '0;
    check(inReady[0] == 1'b0, "R5", 64'(inReady[0]), 64'd0);
    check(outValid[2] && outData[2] == mk(5, 2, 'h100), "R6", 64'(outData[2]), 64'(mk(5, 2, 'h100)));
    @(negedge clk);
    check(outValid[2] && outData[2] == mk(5, 2, 'h100), "R6", 64'(outData[2]), 64'(mk(5, 2, 'h100)));
    outReady[2] = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      check(outValid[2] && outData[2] == mk(5, 2, 'h100 + k), "R5",
            64'(outData[2]), 64'(mk(5, 2, 'h100 + k)));
      @(negedge clk);
    end
    check(outValid[2] == 1'b0 && inReady[0] == 1'b1, "R5", {outValid[2], inReady[0]}, 2'b01);

    // R7: three inputs compete for east while stalled; last winner was local
    outReady[2] = 1'b0;
    inData[0] = mk(6, 2, 'h200);
    inData[1] = mk(6, 2, 'h201);
    inData[4] = mk(6, 2, 'h204);
    inValid   = 5'b10011;
    @(negedge clk);
    inValid = '0;
    @(negedge clk);
    @(negedge clk);
    check(outData[2] == mk(6, 2, 'h201), "R7", 64'(outData[2]), 64'(mk(6, 2, 'h201)));
    outReady[2] = 1'b1;
    check(outValid[2] && outData[2] == mk(6, 2, 'h201), "R7", 64'(outData[2]), 64'(mk(6, 2, 'h201)));
    @(negedge clk);
    check(outValid[2] && outData[2] == mk(6, 2, 'h204), "R7", 64'(outData[2]), 64'(mk(6, 2, 'h204)));
    @(negedge clk);
    check(outValid[2] && outData[2] == mk(6, 2, 'h200), "R7", 64'(outData[2]), 64'(mk(6, 2, 'h200)));
    @(negedge clk);
    check(outValid[2] == 1'b0, "R7", 64'(outValid[2]), 64'd0);

    // R7: rotation continues after local, so west precedes local
    inData[0] = mk(6, 2, 'h300);
    inData[4] = mk(6, 2, 'h304);
    inValid   = 5'b10001;
    @(negedge clk);
    inValid = '0;
    check(outValid[2] && outData[2] == mk(6, 2, 'h304), "R7", 64'(outData[2]), 64'(mk(6, 2, 'h304)));
    @(negedge clk);
    check(outValid[2] && outData[2] == mk(6, 2, 'h300), "R7", 64'(outData[2]), 64'(mk(6, 2, 'h300)));
    @(negedge clk);

    // R8: distinct outputs in the same cycle
    inData[0] = mk(5, 2, 'h400);
    inData[4] = mk(2, 5, 'h404);
    inValid   = 5'b10001;
    @(negedge clk);
    inValid = '0;
    check(outValid == 5'b00110, "R8", 64'(outValid), 64'b00110);
    check(outData[2] == mk(5, 2, 'h400) && outData[1] == mk(2, 5, 'h404), "R8",
          64'(outData[2]), 64'(mk(5, 2, 'h400)));
    @(negedge clk);
    check(outValid == '0, "R8", 64'(outValid), 64'd0);

    summary();
    $finish;
  end
endmodule